// File: doc/BRIEF.md
# Remote-Forwarded Interrupt Controller

This block turns an interrupt condition that arrives from the far end of a serial link into a local active-low interrupt line for a host processor. The remote condition reaches the block as an already synchronised active-low level. The block captures that level in a sticky pending flag, so a low pulse as short as one clock is not lost. It pulls its own interrupt output low while the pending flag is set and interrupts are enabled.

The host uses a small register port. A control register holds a global enable and a remote-source enable. Both must be set before any interrupt is produced. A status register reports the pending flag and whether the controller is armed. The controller stays inert after configuration until the host reads the status register for the first time. That read arms it. Every later status read returns the flag as it stood and clears it. After a clear, only a low level that follows a high level seen at or after the read raises the flag again. The output is modelled as an open-drain pin: logic 0 pulls low and logic 1 releases.

Top module: `remote_irq_ctrl`

## Requirements
- R1: After reset, both enables are clear, the controller is disarmed, `irq_n` is 1, and both registers read as 0.
- R2: The control register is at address 0. Bit 0 is the global enable and bit 1 is the remote-source enable. Both bits read back as written. Writes to other addresses change nothing.
- R3: Before the first read of the status register, a low on `remote_irq_n` sets no pending flag and leaves `irq_n` at 1.
- R4: A read of the status register (address 1) arms the controller. It stays armed until reset.
- R5: When the controller is armed and both enables are set, a low on `remote_irq_n` sampled at a rising clock edge sets the pending flag. `irq_n` is 0 from that edge onward, even after `remote_irq_n` returns high.
- R6: While either enable is clear, a low on `remote_irq_n` does not set the pending flag.
- R7: While either enable is clear, `irq_n` is 1 even if the flag is pending. Setting both enables again drives `irq_n` low once more.
- R8: A status read returns bit 0 = pending flag and bit 1 = armed, using the values from before the read. The read clears the pending flag, so `irq_n` is 1 after that edge.
- R9: After a clearing read, the flag is set again only by a low that follows a high sampled at or after the read edge. A low held continuously across the read sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a status read takes effect at the clock edge |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the same cycle as `reg_rd` |
| remote_irq_n | input | 1 | Synchronised active-low remote interrupt |
| irq_n | output | 1 | Active-low interrupt; 0 pulls low, 1 releases |

## Verification
A sweep covers every combination of the two enable bits, both armed and disarmed, with a single-cycle low pulse on the remote input. Only the case with both enables set and the controller armed should produce an interrupt and a set status bit. This separates gating by arming from gating by each enable. Further patterns check three things. A low held across a clearing read must not re-raise the flag, while a later high-then-low must. Masking a pending flag must release the output without losing the flag. Back-to-back status reads must show the pre-clear value and then zero.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned GIE_BIT   = 0;
  localparam int unsigned SRC_BIT   = 1;
  localparam int unsigned PEND_BIT  = 0;
  localparam int unsigned ARM_BIT   = 1;
endpackage

// File: rtl/rfi_ctrl_reg.sv
module rfi_ctrl_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              gie,
  output logic              src_en
);
  import rfi_pkg::*;

  logic gie_q, gie_d, src_q, src_d;

  always_comb begin
    gie_d = gie_q;
    src_d = src_q;
    if (wr_en) begin
      gie_d = wdata[GIE_BIT];
      src_d = wdata[SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      gie_q <= gie_d;
      src_q <= src_d;
    end
  end

  assign gie    = gie_q;
  assign src_en = src_q;

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (gie_q == $past(wdata[GIE_BIT]) && src_q == $past(wdata[SRC_BIT])));
endmodule

// File: rtl/rfi_latch.sv
module rfi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_all,
  input  logic rd_stat,
  input  logic remote_n,
  output logic armed,
  output logic pending
);
  logic arm_q, arm_d;
  logic seen_q, seen_d;
  logic pend_q, pend_d;
  logic fire;

  always_comb begin
    fire   = arm_q & en_all & seen_q & ~remote_n;
    arm_d  = arm_q | rd_stat;
    seen_d = rd_stat ? remote_n : (seen_q | remote_n);
    pend_d = rd_stat ? 1'b0 : (pend_q | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      seen_q <= seen_d;
      pend_q <= pend_d;
    end
  end

  assign armed   = arm_q;
  assign pending = pend_q;

  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q ##1 pend_q) |-> $past(arm_q && en_all && !remote_n));
  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !pend_q);
  // R4
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);
endmodule

// File: rtl/remote_irq_ctrl.sv
module remote_irq_ctrl #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              remote_irq_n,
  output logic              irq_n
);
  import rfi_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic gie, src_en, en_all, armed, pending;
  logic wr_ctrl, rd_stat;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);
  assign en_all  = gie & src_en;

  rfi_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wdata  (reg_wdata),
    .gie    (gie),
    .src_en (src_en)
  );

  rfi_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_all   (en_all),
    .rd_stat  (rd_stat),
    .remote_n (remote_irq_n),
    .armed    (armed),
    .pending  (pending)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_CTRL) begin
        reg_rdata[GIE_BIT] = gie;
        reg_rdata[SRC_BIT] = src_en;
      end else if (reg_addr == A_STAT) begin
        reg_rdata[PEND_BIT] = pending;
        reg_rdata[ARM_BIT]  = armed;
      end
    end
  end

  assign irq_n = ~(pending & en_all);

  // R3
  irq_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> armed);
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || !src_en) |-> irq_n);
endmodule

// File: tb/tb_remote_irq_ctrl.sv
module tb_remote_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       remote_irq_n;
  logic       irq_n;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  remote_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .remote_irq_n(remote_irq_n), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; remote_irq_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_low();
    @(negedge clk);
    remote_irq_n = 1'b0;
    @(negedge clk);
    remote_irq_n = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    rd(2'd0, rv); chk("R1 ctrl", rv, 0);
    rd(2'd1, rv); chk("R1 status", rv, 0);

    // R2 readback and ignored address
    do_reset();
    wr(2'd0, 8'h02); rd(2'd0, rv); chk("R2 src only", rv, 2);
    wr(2'd0, 8'h01); rd(2'd0, rv); chk("R2 gie only", rv, 1);
    wr(2'd2, 8'h03); rd(2'd0, rv); chk("R2 other addr ignored", rv, 1);

    // Sweep: enables x armed (R3 R4 R5 R6 R8)
    for (int cfg = 0; cfg < 8; cfg++) begin
      automatic int en  = cfg & 3;
      automatic int arm = (cfg >> 2) & 1;
      automatic int hit = (en == 3 && arm == 1) ? 1 : 0;
      do_reset();
      wr(2'd0, 8'(en));
      if (arm == 1) rd(2'd1, rv);
      pulse_low();
      @(negedge clk);
      chk(arm == 0 ? "R3 irq_n disarmed" : (en == 3 ? "R5 irq_n" : "R6 irq_n"),
          irq_n, hit ? 0 : 1);
      rd(2'd1, rv);
      chk(arm == 0 ? "R3 pend bit" : "R6 pend bit", rv[0], hit);
      chk("R4 arm bit", rv[1], arm);
      chk("R8 irq_n after read", irq_n, 1);
    end

    // R8 back-to-back reads: pre-clear value then zero
    do_reset();
    wr(2'd0, 8'h03); rd(2'd1, rv);
    pulse_low();
    rd(2'd1, rv); chk("R8 first read", rv, 3);
    rd(2'd1, rv); chk("R8 second read", rv, 2);

    // R9 low held across read does not re-raise
    @(negedge clk); remote_irq_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 sticky low", irq_n, 0);
    rd(2'd1, rv);
    repeat (3) @(negedge clk);
    chk("R9 held low no reassert", irq_n, 1);
    remote_irq_n = 1'b1;
    @(negedge clk);
    remote_irq_n = 1'b0;
    @(negedge clk);
    remote_irq_n = 1'b1;
    chk("R9 new edge reasserts", irq_n, 0);

    // R7 masking keeps pending
    wr(2'd0, 8'h01);
    chk("R7 masked src", irq_n, 1);
    wr(2'd0, 8'h02);
    chk("R7 masked gie", irq_n, 1);
    wr(2'd0, 8'h03);
    chk("R7 unmasked", irq_n, 0);
    rd(2'd1, rv); chk("R7 pend kept", rv[0], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule